// File: doc/BRIEF.md
# Serial Command Port for an LF Transmitter Controller

This block is the controller-facing serial port of a low-frequency transmitter. An external microcontroller acts as bus master. It frames each exchange with an active-low select line and moves 8-bit words least-significant bit first. The port decodes a small command set. The commands set or read back two configuration bytes, read a status byte supplied by the fault logic, stream a run of data bytes into the transmit buffer and then start the transmission, clear latched faults, and put the transmitter to sleep.

All serial pins are brought into the system clock domain through two-flop synchronisers. Data-in is taken on the rising serial clock. Data-out moves on the falling serial clock and is only driven while select is active; the enable output controls the tri-state pad.

The port leaves reset asleep. A sleeping port ignores every word it receives. It wakes once select has been held low for a programmable number of system clocks, and it decodes words again from the next select assertion. Releasing select on its own only returns the port to idle: the configuration is kept and nothing downstream is interrupted.

Top module: `spi_lf_if`

## Requirements
- R1: A word is 8 bits taken LSB first on rising serial clock edges; command byte 0x01 followed by a data byte loads that byte into configuration A.
- R2: The data-out enable is low whenever select is inactive and high whenever select is active.
- R3: Command 0x02 (configuration A), 0x04 (configuration B) or 0x05 (status input) makes the next word of the same frame shift that byte out LSB first, each bit valid before the rising serial clock edge that takes it.
- R4: Command byte 0x03 followed by a data byte loads configuration B.
- R5: Command byte with low nibble 0x6 and a non-zero high nibble N is followed by N data words; each word is presented once on the buffer write strobe in arrival order, and the transmit start pulse coincides with the last write.
- R6: Command byte 0x07 produces exactly one single-cycle fault-clear pulse.
- R7: Command byte 0x08 sets the sleep output; later words in that frame and in any frame that starts while asleep change no register and produce no strobe.
- R8: While asleep, select held low for WAKE_CYC consecutive system clocks clears the sleep output; a shorter assertion does not.
- R9: Reset returns configuration A and B to their default parameters and sets the sleep output.
- R10: Deasserting select part way through a word discards the partial word and returns decoding to the command stage, so the next frame starts with a fresh command.
- R11: A command byte whose low nibble is not one of the defined codes (for example 0x0E or 0x00) changes no register and produces no pulse.
- R12: Releasing select without the sleep command leaves the sleep output low and both configuration bytes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_csn | input | 1 | Serial select, active low |
| spi_sck | input | 1 | Serial clock from the master |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |
| spi_miso_oe | output | 1 | Drive enable for the data-out pad |
| status_in | input | 8 | Status byte from the fault logic |
| cfg_a | output | 8 | Configuration byte A |
| cfg_b | output | 8 | Configuration byte B |
| buf_we | output | 1 | Transmit buffer write strobe |
| buf_data | output | 8 | Transmit buffer write data |
| tx_start | output | 1 | Pulse that starts the transmission |
| fault_clr | output | 1 | Pulse that clears latched faults |
| powered_down | output | 1 | High while the transmitter is asleep |

## Verification
The bench drives asymmetric data patterns such as 0xA5 and 0x3C, and a status value of 0x96. A reversed bit order or a shifted bit position gives a different byte, so these patterns expose it. Readbacks of both configuration bytes and of the status input show whether the shift-out path is loaded at the right falling edge. A three-word buffer load with distinct bytes checks both the order of the writes and that the start pulse falls on the last one. Truncated frames, undefined opcodes, trailing words after the sleep command, and a short select pulse next to a long one each separate "ignored" from "acted upon", and the configuration outputs are compared against the model on every clock.

// File: rtl/spi_lf_pkg.sv
package spi_lf_pkg;

    localparam int WORD_W = 8;
    localparam int OP_W   = 4;
    localparam int CNT_W  = WORD_W - OP_W;
    localparam int BIT_W  = $clog2(WORD_W);
    localparam int SYNC_N = 2;

    typedef enum logic [OP_W-1:0] {
        OP_NOP   = 4'h0,
        OP_WR_A  = 4'h1,
        OP_RD_A  = 4'h2,
        OP_WR_B  = 4'h3,
        OP_RD_B  = 4'h4,
        OP_RD_ST = 4'h5,
        OP_LOAD  = 4'h6,
        OP_CLR   = 4'h7,
        OP_SLEEP = 4'h8
    } op_e;

    typedef enum logic [2:0] {
        ST_CMD,
        ST_WR_A,
        ST_WR_B,
        ST_RD,
        ST_LOAD
    } dec_st_e;

    typedef struct packed {
        logic rise;
        logic fall;
        logic cs_act;
        logic cs_start;
        logic cs_stop;
        logic mosi;
    } pin_ev_t;

    function automatic op_e op_of(input logic [WORD_W-1:0] w);
        return op_e'(w[OP_W-1:0]);
    endfunction

    function automatic logic [CNT_W-1:0] cnt_of(input logic [WORD_W-1:0] w);
        return w[WORD_W-1:OP_W];
    endfunction

endpackage

// File: rtl/spi_lf_sync.sv
module spi_lf_sync
    import spi_lf_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    csn,
    input  logic    sck,
    input  logic    mosi,
    output pin_ev_t ev
);
    logic [SYNC_N-1:0] csn_q;
    logic [SYNC_N-1:0] sck_q;
    logic [SYNC_N-1:0] mosi_q;
    logic              sck_d;
    logic              csn_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            csn_q  <= '1;
            sck_q  <= '0;
            mosi_q <= '0;
            sck_d  <= 1'b0;
            csn_d  <= 1'b1;
        end else begin
            csn_q  <= {csn_q[SYNC_N-2:0], csn};
            sck_q  <= {sck_q[SYNC_N-2:0], sck};
            mosi_q <= {mosi_q[SYNC_N-2:0], mosi};
            sck_d  <= sck_q[SYNC_N-1];
            csn_d  <= csn_q[SYNC_N-1];
        end
    end

    always_comb begin
        ev.rise     = sck_q[SYNC_N-1] & ~sck_d;
        ev.fall     = ~sck_q[SYNC_N-1] & sck_d;
        ev.cs_act   = ~csn_q[SYNC_N-1];
        ev.cs_start = csn_d & ~csn_q[SYNC_N-1];
        ev.cs_stop  = ~csn_d & csn_q[SYNC_N-1];
        ev.mosi     = mosi_q[SYNC_N-1];
    end

endmodule

// File: rtl/spi_lf_shift.sv
module spi_lf_shift
    import spi_lf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  pin_ev_t           ev,
    input  logic              asleep,
    input  logic              rd_load,
    input  logic [WORD_W-1:0] rd_val,
    output logic              word_done,
    output logic [WORD_W-1:0] word,
    output logic              miso
);
    logic              frame_ok;
    logic [BIT_W-1:0]  bit_cnt;
    logic [WORD_W-1:0] rx_sh;
    logic [WORD_W-1:0] tx_sh;
    logic [WORD_W-1:0] rd_hold;
    logic              rd_pend;
    logic              last_bit;

    assign last_bit = (bit_cnt == BIT_W'(WORD_W - 1));
    assign miso     = tx_sh[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_ok  <= 1'b0;
            bit_cnt   <= '0;
            rx_sh     <= '0;
            tx_sh     <= '0;
            rd_hold   <= '0;
            rd_pend   <= 1'b0;
            word_done <= 1'b0;
            word      <= '0;
        end else begin
            word_done <= 1'b0;

            if (ev.cs_start)
                frame_ok <= ~asleep;
            else if (ev.cs_stop || asleep)
                frame_ok <= 1'b0;

            if (!ev.cs_act) begin
                bit_cnt <= '0;
                tx_sh   <= '0;
                rd_pend <= 1'b0;
            end else begin
                if (frame_ok && ev.rise) begin
                    rx_sh <= {ev.mosi, rx_sh[WORD_W-1:1]};
                    if (last_bit) begin
                        bit_cnt   <= '0;
                        word_done <= 1'b1;
                        word      <= {ev.mosi, rx_sh[WORD_W-1:1]};
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                if (rd_load) begin
                    rd_pend <= 1'b1;
                    rd_hold <= rd_val;
                end else if (ev.fall) begin
                    if (rd_pend) begin
                        tx_sh   <= rd_hold;
                        rd_pend <= 1'b0;
                    end else begin
                        tx_sh <= {1'b0, tx_sh[WORD_W-1:1]};
                    end
                end
            end
        end
    end

endmodule

// File: rtl/spi_lf_ctrl.sv
module spi_lf_ctrl
    import spi_lf_pkg::*;
#(
    parameter logic [WORD_W-1:0] CFG_A_DEF = 8'h1F,
    parameter logic [WORD_W-1:0] CFG_B_DEF = 8'h40,
    parameter int                WAKE_CYC  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_act,
    input  logic              word_done,
    input  logic [WORD_W-1:0] word,
    input  logic [WORD_W-1:0] status_in,
    output logic [WORD_W-1:0] cfg_a,
    output logic [WORD_W-1:0] cfg_b,
    output logic              asleep,
    output logic              rd_load,
    output logic [WORD_W-1:0] rd_val,
    output logic              buf_we,
    output logic [WORD_W-1:0] buf_data,
    output logic              tx_start,
    output logic              fault_clr
);
    localparam int WK_W = $clog2(WAKE_CYC + 1);

    dec_st_e          st;
    logic [CNT_W-1:0] left;
    logic [WK_W-1:0]  wake_cnt;
    logic             wake_arm;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_a     <= CFG_A_DEF;
            cfg_b     <= CFG_B_DEF;
            asleep    <= 1'b1;
            st        <= ST_CMD;
            left      <= '0;
            wake_cnt  <= '0;
            wake_arm  <= 1'b0;
            rd_load   <= 1'b0;
            rd_val    <= '0;
            buf_we    <= 1'b0;
            buf_data  <= '0;
            tx_start  <= 1'b0;
            fault_clr <= 1'b0;
        end else begin
            rd_load   <= 1'b0;
            buf_we    <= 1'b0;
            tx_start  <= 1'b0;
            fault_clr <= 1'b0;

            if (!cs_act) begin
                wake_arm <= 1'b1;
                wake_cnt <= '0;
            end else if (asleep && wake_arm) begin
                if (wake_cnt == WK_W'(WAKE_CYC - 1)) begin
                    asleep   <= 1'b0;
                    wake_cnt <= '0;
                end else begin
                    wake_cnt <= wake_cnt + 1'b1;
                end
            end

            if (!cs_act) begin
                st <= ST_CMD;
            end else if (word_done) begin
                unique case (st)
                    ST_CMD: begin
                        case (op_of(word))
                            OP_WR_A: st <= ST_WR_A;
                            OP_WR_B: st <= ST_WR_B;
                            OP_RD_A: begin
                                rd_load <= 1'b1;
                                rd_val  <= cfg_a;
                                st      <= ST_RD;
                            end
                            OP_RD_B: begin
                                rd_load <= 1'b1;
                                rd_val  <= cfg_b;
                                st      <= ST_RD;
                            end
                            OP_RD_ST: begin
                                rd_load <= 1'b1;
                                rd_val  <= status_in;
                                st      <= ST_RD;
                            end
                            OP_LOAD: begin
                                if (cnt_of(word) != '0) begin
                                    left <= cnt_of(word);
                                    st   <= ST_LOAD;
                                end
                            end
                            OP_CLR: fault_clr <= 1'b1;
                            OP_SLEEP: begin
                                asleep   <= 1'b1;
                                wake_arm <= 1'b0;
                                wake_cnt <= '0;
                            end
                            default: ;
                        endcase
                    end
                    ST_WR_A: begin
                        cfg_a <= word;
                        st    <= ST_CMD;
                    end
                    ST_WR_B: begin
                        cfg_b <= word;
                        st    <= ST_CMD;
                    end
                    ST_RD: st <= ST_CMD;
                    ST_LOAD: begin
                        buf_we   <= 1'b1;
                        buf_data <= word;
                        left     <= left - 1'b1;
                        if (left == CNT_W'(1)) begin
                            tx_start <= 1'b1;
                            st       <= ST_CMD;
                        end
                    end
                    default: st <= ST_CMD;
                endcase
            end
        end
    end

endmodule

// File: rtl/spi_lf_if.sv
module spi_lf_if
    import spi_lf_pkg::*;
#(
    parameter logic [WORD_W-1:0] CFG_A_DEF = 8'h1F,
    parameter logic [WORD_W-1:0] CFG_B_DEF = 8'h40,
    parameter int                WAKE_CYC  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              spi_csn,
    input  logic              spi_sck,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic              spi_miso_oe,
    input  logic [WORD_W-1:0] status_in,
    output logic [WORD_W-1:0] cfg_a,
    output logic [WORD_W-1:0] cfg_b,
    output logic              buf_we,
    output logic [WORD_W-1:0] buf_data,
    output logic              tx_start,
    output logic              fault_clr,
    output logic              powered_down
);
    pin_ev_t           ev;
    logic              word_done;
    logic [WORD_W-1:0] word;
    logic              rd_load;
    logic [WORD_W-1:0] rd_val;
    logic              asleep;

    spi_lf_sync u_sync (
        .clk  (clk),
        .rst  (rst),
        .csn  (spi_csn),
        .sck  (spi_sck),
        .mosi (spi_mosi),
        .ev   (ev)
    );

    spi_lf_shift u_shift (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev),
        .asleep    (asleep),
        .rd_load   (rd_load),
        .rd_val    (rd_val),
        .word_done (word_done),
        .word      (word),
        .miso      (spi_miso)
    );

    spi_lf_ctrl #(
        .CFG_A_DEF (CFG_A_DEF),
        .CFG_B_DEF (CFG_B_DEF),
        .WAKE_CYC  (WAKE_CYC)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .cs_act    (ev.cs_act),
        .word_done (word_done),
        .word      (word),
        .status_in (status_in),
        .cfg_a     (cfg_a),
        .cfg_b     (cfg_b),
        .asleep    (asleep),
        .rd_load   (rd_load),
        .rd_val    (rd_val),
        .buf_we    (buf_we),
        .buf_data  (buf_data),
        .tx_start  (tx_start),
        .fault_clr (fault_clr)
    );

    assign spi_miso_oe  = ev.cs_act;
    assign powered_down = asleep;

endmodule

// File: rtl/spi_lf_chk.sv
module spi_lf_chk
    import spi_lf_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              spi_csn,
    input logic              spi_miso_oe,
    input logic [WORD_W-1:0] cfg_a,
    input logic [WORD_W-1:0] cfg_b,
    input logic              buf_we,
    input logic              tx_start,
    input logic              fault_clr,
    input logic              powered_down
);
    // R2: the pad drive follows select through the two-flop synchroniser
    a_r2_miso_off: assert property (@(posedge clk) disable iff (rst)
        (spi_csn && $past(spi_csn) && $past(spi_csn, 2)) |-> !spi_miso_oe);

    // R5: the start pulse only comes with a buffer write
    a_r5_start_on_write: assert property (@(posedge clk) disable iff (rst)
        tx_start |-> buf_we);

    // R5: buffer writes are whole words apart
    a_r5_write_spacing: assert property (@(posedge clk) disable iff (rst)
        buf_we |=> !buf_we);

    // R6: fault clear is a single-cycle pulse
    a_r6_clr_single: assert property (@(posedge clk) disable iff (rst)
        fault_clr |=> !fault_clr);

    // R7: nothing is written while asleep
    a_r7_sleep_holds: assert property (@(posedge clk) disable iff (rst)
        (powered_down && $past(powered_down)) |-> ($stable(cfg_a) && $stable(cfg_b) && !buf_we && !fault_clr));

    // R8: waking needs select held active
    a_r8_wake_cs: assert property (@(posedge clk) disable iff (rst)
        $fell(powered_down) |-> !$past(spi_csn, 3));

endmodule

bind spi_lf_if spi_lf_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .spi_csn      (spi_csn),
    .spi_miso_oe  (spi_miso_oe),
    .cfg_a        (cfg_a),
    .cfg_b        (cfg_b),
    .buf_we       (buf_we),
    .tx_start     (tx_start),
    .fault_clr    (fault_clr),
    .powered_down (powered_down)
);

// File: tb/sim_spi_lf_if.sv
`timescale 1ns/1ps
module sim_spi_lf_if;
    localparam int          HALF = 8;
    localparam logic [7:0]  DA   = 8'h1F;
    localparam logic [7:0]  DB   = 8'h40;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       csn = 1'b1;
    logic       sck = 1'b0;
    logic       mosi = 1'b0;
    logic [7:0] status_in = 8'h96;
    logic       miso, miso_oe, buf_we, tx_start, fault_clr, pd;
    logic [7:0] cfg_a, cfg_b, buf_data;

    spi_lf_if #(.CFG_A_DEF(DA), .CFG_B_DEF(DB), .WAKE_CYC(16)) u0 (
        .clk(clk), .rst(rst), .spi_csn(csn), .spi_sck(sck), .spi_mosi(mosi),
        .spi_miso(miso), .spi_miso_oe(miso_oe), .status_in(status_in),
        .cfg_a(cfg_a), .cfg_b(cfg_b), .buf_we(buf_we), .buf_data(buf_data),
        .tx_start(tx_start), .fault_clr(fault_clr), .powered_down(pd)
    );

    always #5 clk = ~clk;

    int         n_chk = 0;
    int         n_fail = 0;
    bit         chk_en = 0;
    logic [7:0] ma = DA;
    logic [7:0] mb = DB;
    logic       mpd = 1'b1;
    logic [7:0] got[$];
    int         n_start = 0;
    int         start_idx = -1;
    int         n_clr = 0;
    int         hi_run = 0;
    int         lo_run = 0;
    logic [7:0] r;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        if (!rst) begin
            if (buf_we) got.push_back(buf_data);
            if (tx_start) begin
                n_start++;
                start_idx = got.size();
            end
            if (fault_clr) n_clr++;
        end
    end

    // per-clock comparison with the behavioural model
    always @(posedge clk) begin
        #2;
        if (rst) begin
            hi_run = 0;
            lo_run = 0;
        end else begin
            if (csn) begin hi_run++; lo_run = 0; end
            else     begin lo_run++; hi_run = 0; end
            if (hi_run >= 3) chk("R2 oe idle", {31'd0, miso_oe}, 32'd0);
            if (lo_run >= 3) chk("R2 oe active", {31'd0, miso_oe}, 32'd1);
            if (chk_en) begin
                chk("R7/R12 cfg_a model", {24'd0, cfg_a}, {24'd0, ma});
                chk("R7/R12 cfg_b model", {24'd0, cfg_b}, {24'd0, mb});
                chk("R8/R12 sleep model", {31'd0, pd}, {31'd0, mpd});
            end
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cs_on();
        chk_en = 0;
        csn = 1'b0;
        cyc(HALF);
    endtask

    task automatic cs_off();
        cyc(HALF);
        csn = 1'b1;
        cyc(4 * HALF);
        chk_en = 1;
    endtask

    task automatic xbits(input logic [7:0] tx, input int nb, output logic [7:0] rx);
        rx = 8'h00;
        for (int i = 0; i < nb; i++) begin
            mosi = tx[i];
            cyc(HALF);
            rx[i] = miso;
            sck = 1'b1;
            cyc(HALF);
            sck = 1'b0;
        end
    endtask

    initial begin
        cyc(150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        cyc(5);
        rst = 1'b0;
        cyc(2);
        chk("R9 cfg_a default", {24'd0, cfg_a}, {24'd0, DA});
        chk("R9 cfg_b default", {24'd0, cfg_b}, {24'd0, DB});
        chk("R9 asleep", {31'd0, pd}, 32'd1);
        chk("R2 oe after reset", {31'd0, miso_oe}, 32'd0);
        chk_en = 1;

        // R8: short pulse keeps sleeping, long pulse wakes
        chk_en = 0;
        csn = 1'b0; cyc(6); csn = 1'b1; cyc(10);
        chk("R8 short pulse", {31'd0, pd}, 32'd1);
        csn = 1'b0; cyc(30); csn = 1'b1; cyc(10);
        mpd = 1'b0;
        chk("R8 long pulse", {31'd0, pd}, 32'd0);
        chk_en = 1;

        // R1
        cs_on(); xbits(8'h01, 8, r); xbits(8'hA5, 8, r); ma = 8'hA5; cs_off();
        chk("R1 cfg_a A5", {24'd0, cfg_a}, 32'hA5);
        // R4
        cs_on(); xbits(8'h03, 8, r); xbits(8'h3C, 8, r); mb = 8'h3C; cs_off();
        chk("R4 cfg_b 3C", {24'd0, cfg_b}, 32'h3C);
        // R3
        cs_on(); xbits(8'h02, 8, r); xbits(8'h00, 8, r); cs_off();
        chk("R3 read cfg_a", {24'd0, r}, 32'hA5);
        cs_on(); xbits(8'h04, 8, r); xbits(8'h00, 8, r); cs_off();
        chk("R3 read cfg_b", {24'd0, r}, 32'h3C);
        cs_on(); xbits(8'h05, 8, r); xbits(8'h00, 8, r); cs_off();
        chk("R3 read status", {24'd0, r}, 32'h96);

        // R11
        cs_on(); xbits(8'h0E, 8, r); xbits(8'h00, 8, r); cs_off();
        chk("R11 cfg_a kept", {24'd0, cfg_a}, 32'hA5);
        chk("R11 no clear", n_clr, 0);
        chk("R11 no write", got.size(), 0);

        // R10
        cs_on(); xbits(8'h01, 5, r); cs_off();
        cs_on(); xbits(8'h03, 8, r); xbits(8'hFF, 3, r); cs_off();
        chk("R10 partial data dropped", {24'd0, cfg_b}, 32'h3C);
        cs_on(); xbits(8'h01, 8, r); xbits(8'h5A, 8, r); ma = 8'h5A; cs_off();
        chk("R10 fresh command", {24'd0, cfg_a}, 32'h5A);

        // R5
        cs_on(); xbits(8'h36, 8, r); xbits(8'h11, 8, r); xbits(8'h22, 8, r); xbits(8'h33, 8, r); cs_off();
        chk("R5 write count", got.size(), 3);
        if (got.size() == 3) begin
            chk("R5 word 0", {24'd0, got[0]}, 32'h11);
            chk("R5 word 1", {24'd0, got[1]}, 32'h22);
            chk("R5 word 2", {24'd0, got[2]}, 32'h33);
        end
        chk("R5 start count", n_start, 1);
        chk("R5 start on last", start_idx, 3);

        // R6
        cs_on(); xbits(8'h07, 8, r); cs_off();
        chk("R6 clear pulses", n_clr, 1);

        // R12
        chk("R12 awake after releases", {31'd0, pd}, 32'd0);
        chk("R12 cfg_b kept", {24'd0, cfg_b}, 32'h3C);

        // R7
        cs_on(); xbits(8'h08, 8, r); xbits(8'h01, 8, r); xbits(8'hFF, 8, r); mpd = 1'b1; cs_off();
        chk("R7 asleep", {31'd0, pd}, 32'd1);
        chk("R7 trailing ignored", {24'd0, cfg_a}, 32'h5A);
        cs_on(); xbits(8'h01, 8, r); xbits(8'h00, 8, r); mpd = 1'b0; cs_off();
        chk("R7 frame while asleep ignored", {24'd0, cfg_a}, 32'h5A);
        chk("R8 woke during frame", {31'd0, pd}, 32'd0);
        cs_on(); xbits(8'h03, 8, r); xbits(8'h81, 8, r); mb = 8'h81; cs_off();
        chk("R4 cfg_b after wake", {24'd0, cfg_b}, 32'h81);

        // R9
        chk_en = 0;
        rst = 1'b1; cyc(3); rst = 1'b0;
        ma = DA; mb = DB; mpd = 1'b1;
        cyc(2);
        chk("R9 cfg_a reset", {24'd0, cfg_a}, {24'd0, DA});
        chk("R9 cfg_b reset", {24'd0, cfg_b}, {24'd0, DB});
        chk("R9 asleep again", {31'd0, pd}, 32'd1);
        chk_en = 1;
        cyc(10);
        finish_run();
    end

endmodule